// File: doc/BRIEF.md
# Reset Sequence Manager

This block merges three reset requests into one internal core reset and controls the order in which the core leaves reset. The three requests are a level from the low-voltage detector, a single-cycle pulse from the watchdog, and the external active-low reset pad. For each request the block pulls the open-drain reset pad low for a time that depends on the source. It then holds the core in reset for a fixed stabilisation count. Finally it runs a two-cycle fetch of the reset vector, and the core starts running after that fetch.

The external pad is first synchronised. A low level on it counts as a request only once it has been held for a minimum number of consecutive samples. While the block drives the pad itself, and for a short time after it lets go, the pad input is ignored, so the block does not re-trigger on its own drive. Two sticky cause flags record whether a low-voltage reset or a watchdog reset has occurred. Software clears a flag by writing zero to its bit.

Top module: `rsm_top`

## Requirements
- R1: Each of the three sources starts a reset sequence. When several sources request in the same cycle, the delay length follows the priority low-voltage, then watchdog, then external.
- R2: The pad drive output is high for exactly the delay phase. The delay phase lasts WDG_HOLD (default 8) cycles for a watchdog request and EXT_HOLD (default 16) cycles for an external request. The core reset is high throughout the delay phase.
- R3: In every cycle after an edge that sampled lvd_i high, the block is in the delay phase with the pad driven. After the last edge that sampled lvd_i high, the pad stays driven for LVD_HOLD (default 32) cycles, counting the cycle that follows that edge.
- R4: A low on ext_rst_n_i is recognised only after FILT_CYC (default 4) consecutive low samples. A shorter pulse has no effect on the pad drive or on the core reset.
- R5: After the delay phase, the core reset stays high for STAB_CYC (default 4096) cycles plus the two fetch cycles, and the pad is released during those cycles.
- R6: The vector fetch lasts two cycles with vec_fetch_o high. vec_addr_o is 16'hFFFE in the first fetch cycle and 16'hFFFF in the second.
- R7: core_rst_o falls in the cycle after the second fetch cycle and then stays low until a new request arrives.
- R8: A new request in any phase, including the stabilisation and fetch phases, restarts the sequence at the start of the delay phase.
- R9: Bit 0 of cause_flags_o is set by a low-voltage request, and bit 1 is set by a watchdog request. An external request sets neither bit.
- R10: A write (flag_wr_i high) clears each flag whose bit in flag_wdata_i is 0 and leaves unchanged each flag whose bit is 1.
- R11: If a source sets a flag in the same cycle that a write clears it, the flag ends up set.
- R12: The synchronous reset rst clears both flags, holds core_rst_o and the pad drive high, and is followed by an EXT_HOLD-cycle delay phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst_n_i | input | 1 | Reset pad level as sensed, active low |
| lvd_i | input | 1 | Low-voltage detect level, active high |
| wdg_pulse_i | input | 1 | Watchdog reset request, one-cycle pulse |
| flag_wr_i | input | 1 | Write strobe for the cause flags |
| flag_wdata_i | input | 2 | Write data: 0 clears the flag, 1 keeps it |
| rst_pin_drive_o | output | 1 | High pulls the open-drain reset pad low |
| core_rst_o | output | 1 | Internal reset for the core |
| vec_fetch_o | output | 1 | High during the reset vector fetch |
| vec_addr_o | output | 16 | Address of the vector fetch, 0 otherwise |
| cause_flags_o | output | 2 | Sticky cause flags: bit 0 low-voltage, bit 1 watchdog |

## Verification
Two events can land on the same edge. One is a software clear and a watchdog set of the same flag, which the bench provokes by asserting flag_wr_i with zero data together with wdg_pulse_i. It judges the result by the flag value on the next cycle, which must be set. The other is a fresh request arriving while a sequence is in the stabilisation or fetch phase. The bench injects a watchdog pulse on the first fetch cycle and an external pulse in the middle of the stabilisation count, and then requires the delay phase to begin again at full length.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  typedef enum logic [4:0] {
    PH_DELAY    = 5'b00001,
    PH_STAB     = 5'b00010,
    PH_FETCH_LO = 5'b00100,
    PH_FETCH_HI = 5'b01000,
    PH_RUN      = 5'b10000
  } rsm_phase_e;

  localparam logic [15:0] VEC_ADDR_LO = 16'hFFFE;
  localparam logic [15:0] VEC_ADDR_HI = 16'hFFFF;
  localparam int unsigned NUM_FLAGS   = 2;
endpackage

// File: rtl/rsm_ext_filter.sv
module rsm_ext_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pad_n_i,
  input  logic self_drive_i,
  output logic ext_req_o
);
  localparam int unsigned BW = $clog2(SYNC_STAGES + 1);
  localparam int unsigned FW = $clog2(FILT_CYC) + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [BW-1:0]          blank_q;
  logic [FW-1:0]          run_q;
  logic                   pad_s;

  // synchroniser chain, idle level high
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pad_n_i};
  end
  assign pad_s = sync_q[SYNC_STAGES-1];

  // ignore the pad while driving it and until the chain has flushed
  always_ff @(posedge clk) begin
    if (rst)                 blank_q <= '0;
    else if (self_drive_i)   blank_q <= BW'(SYNC_STAGES);
    else if (blank_q != '0)  blank_q <= blank_q - BW'(1);
  end

  // consecutive-low counter, saturating at FILT_CYC-1
  always_ff @(posedge clk) begin
    if (rst)                              run_q <= '0;
    else if (blank_q != '0 || pad_s)      run_q <= '0;
    else if (run_q != FW'(FILT_CYC - 1))  run_q <= run_q + FW'(1);
  end

  assign ext_req_o = (blank_q == '0) && !pad_s && (run_q == FW'(FILT_CYC - 1));
endmodule

// File: rtl/rsm_seq_fsm.sv
module rsm_seq_fsm
  import rsm_pkg::*;
#(
  parameter int unsigned EXT_HOLD = 16,
  parameter int unsigned WDG_HOLD = 8,
  parameter int unsigned LVD_HOLD = 32,
  parameter int unsigned STAB_CYC = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ext_req_i,
  input  logic        wdg_req_i,
  input  logic        lvd_req_i,
  output logic        pad_drive_o,
  output logic        core_rst_o,
  output logic        fetch_o,
  output logic [15:0] fetch_addr_o
);
  localparam int unsigned M1   = (EXT_HOLD > WDG_HOLD) ? EXT_HOLD : WDG_HOLD;
  localparam int unsigned M2   = (M1 > LVD_HOLD) ? M1 : LVD_HOLD;
  localparam int unsigned MAXV = (M2 > STAB_CYC) ? M2 : STAB_CYC;
  localparam int unsigned CW   = $clog2(MAXV + 1);

  rsm_phase_e     ph_q, ph_n;
  logic [CW-1:0]  cnt_q, cnt_n;

  always_comb begin
    ph_n  = ph_q;
    cnt_n = cnt_q;
    if (lvd_req_i) begin
      ph_n  = PH_DELAY;
      cnt_n = CW'(LVD_HOLD - 1);
    end else if (wdg_req_i) begin
      ph_n  = PH_DELAY;
      cnt_n = CW'(WDG_HOLD - 1);
    end else if (ext_req_i) begin
      ph_n  = PH_DELAY;
      cnt_n = CW'(EXT_HOLD - 1);
    end else begin
      case (ph_q)
        PH_DELAY: begin
          if (cnt_q == '0) begin
            ph_n  = PH_STAB;
            cnt_n = CW'(STAB_CYC - 1);
          end else begin
            cnt_n = cnt_q - CW'(1);
          end
        end
        PH_STAB: begin
          if (cnt_q == '0) ph_n = PH_FETCH_LO;
          else             cnt_n = cnt_q - CW'(1);
        end
        PH_FETCH_LO: ph_n = PH_FETCH_HI;
        PH_FETCH_HI: ph_n = PH_RUN;
        PH_RUN:      ph_n = PH_RUN;
        default: begin
          ph_n  = PH_DELAY;
          cnt_n = CW'(EXT_HOLD - 1);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q         <= PH_DELAY;
      cnt_q        <= CW'(EXT_HOLD - 1);
      pad_drive_o  <= 1'b1;
      core_rst_o   <= 1'b1;
      fetch_o      <= 1'b0;
      fetch_addr_o <= '0;
    end else begin
      ph_q         <= ph_n;
      cnt_q        <= cnt_n;
      pad_drive_o  <= (ph_n == PH_DELAY);
      core_rst_o   <= (ph_n != PH_RUN);
      fetch_o      <= (ph_n == PH_FETCH_LO) || (ph_n == PH_FETCH_HI);
      fetch_addr_o <= (ph_n == PH_FETCH_LO) ? VEC_ADDR_LO :
                      (ph_n == PH_FETCH_HI) ? VEC_ADDR_HI : 16'h0000;
    end
  end
endmodule

// File: rtl/rsm_cause_flags.sv
module rsm_cause_flags
  import rsm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic                 wr_i,
  input  logic [NUM_FLAGS-1:0] wdata_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags_o[g] <= 1'b0;
      else     flags_o[g] <= set_i[g] | (flags_o[g] & ~(wr_i & ~wdata_i[g]));
    end
  end
endmodule

// File: rtl/rsm_top.sv
module rsm_top
  import rsm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 4,
  parameter int unsigned EXT_HOLD    = 16,
  parameter int unsigned WDG_HOLD    = 8,
  parameter int unsigned LVD_HOLD    = 32,
  parameter int unsigned STAB_CYC    = 4096
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ext_rst_n_i,
  input  logic        lvd_i,
  input  logic        wdg_pulse_i,
  input  logic        flag_wr_i,
  input  logic [1:0]  flag_wdata_i,
  output logic        rst_pin_drive_o,
  output logic        core_rst_o,
  output logic        vec_fetch_o,
  output logic [15:0] vec_addr_o,
  output logic [1:0]  cause_flags_o
);
  logic ext_req;

  rsm_ext_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_CYC   (FILT_CYC)
  ) u_filt (
    .clk         (clk),
    .rst         (rst),
    .pad_n_i     (ext_rst_n_i),
    .self_drive_i(rst_pin_drive_o),
    .ext_req_o   (ext_req)
  );

  rsm_seq_fsm #(
    .EXT_HOLD(EXT_HOLD),
    .WDG_HOLD(WDG_HOLD),
    .LVD_HOLD(LVD_HOLD),
    .STAB_CYC(STAB_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .ext_req_i   (ext_req),
    .wdg_req_i   (wdg_pulse_i),
    .lvd_req_i   (lvd_i),
    .pad_drive_o (rst_pin_drive_o),
    .core_rst_o  (core_rst_o),
    .fetch_o     (vec_fetch_o),
    .fetch_addr_o(vec_addr_o)
  );

  rsm_cause_flags u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  ({wdg_pulse_i, lvd_i}),
    .wr_i   (flag_wr_i),
    .wdata_i(flag_wdata_i),
    .flags_o(cause_flags_o)
  );
endmodule

// File: rtl/rsm_chk.sv
module rsm_chk (
  input logic        clk,
  input logic        rst,
  input logic        lvd_i,
  input logic        wdg_pulse_i,
  input logic        rst_pin_drive_o,
  input logic        core_rst_o,
  input logic        vec_fetch_o,
  input logic [15:0] vec_addr_o,
  input logic [1:0]  cause_flags_o
);
  // R2
  pad_implies_core_chk: assert property (@(posedge clk) disable iff (rst)
    rst_pin_drive_o |-> core_rst_o);

  // R3
  lvd_holds_pad_chk: assert property (@(posedge clk) disable iff (rst)
    lvd_i |=> rst_pin_drive_o);

  // R6
  fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_fetch_o && vec_addr_o == 16'hFFFE) |=>
      (rst_pin_drive_o || (vec_fetch_o && vec_addr_o == 16'hFFFF)));

  // R7
  release_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst_o) |-> $past(vec_fetch_o && vec_addr_o == 16'hFFFF));

  // R8
  wdg_restart_chk: assert property (@(posedge clk) disable iff (rst)
    wdg_pulse_i |=> rst_pin_drive_o);

  // R9
  lvd_flag_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cause_flags_o[0]) |-> $past(lvd_i));

  // R11
  wdg_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wdg_pulse_i |=> cause_flags_o[1]);
endmodule

bind rsm_top rsm_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .lvd_i          (lvd_i),
  .wdg_pulse_i    (wdg_pulse_i),
  .rst_pin_drive_o(rst_pin_drive_o),
  .core_rst_o     (core_rst_o),
  .vec_fetch_o    (vec_fetch_o),
  .vec_addr_o     (vec_addr_o),
  .cause_flags_o  (cause_flags_o)
);

// File: tb/sim_rsm_top.sv
module sim_rsm_top;
  localparam int FILT = 4;
  localparam int EXTH = 16;
  localparam int WDGH = 8;
  localparam int LVDH = 32;
  localparam int STAB = 4096;

  logic clk = 1'b0;
  logic rst, ext_n, lvd, wdg, fwr;
  logic [1:0]  fwd;
  logic        pin, core, fetch;
  logic [15:0] addr;
  logic [1:0]  flags;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  rsm_top u0 (
    .clk(clk), .rst(rst), .ext_rst_n_i(ext_n), .lvd_i(lvd), .wdg_pulse_i(wdg),
    .flag_wr_i(fwr), .flag_wdata_i(fwd), .rst_pin_drive_o(pin),
    .core_rst_o(core), .vec_fetch_o(fetch), .vec_addr_o(addr), .cause_flags_o(flags)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 delay,1 stab,2 fetch lo,3 fetch hi,4 run
  int m_phase, m_left, m_blank, m_run;
  bit m_s1, m_s2, m_lf, m_wf;
  always @(posedge clk) begin
    bit e_req;
    if (rst) begin
      m_phase = 0; m_left = EXTH; m_blank = 0; m_run = 0;
      m_s1 = 1; m_s2 = 1; m_lf = 0; m_wf = 0;
    end else begin
      e_req = (m_blank == 0) && !m_s2 && (m_run == FILT - 1);
      if (m_blank != 0 || m_s2) m_run = 0;
      else if (m_run < FILT - 1) m_run++;
      if (m_phase == 0) m_blank = 2;
      else if (m_blank > 0) m_blank--;
      m_s2 = m_s1; m_s1 = ext_n;
      m_lf = lvd | (m_lf & !(fwr && !fwd[0]));
      m_wf = wdg | (m_wf & !(fwr && !fwd[1]));
      if (lvd || wdg || e_req) begin
        m_phase = 0;
        m_left  = lvd ? LVDH : (wdg ? WDGH : EXTH);
      end else begin
        case (m_phase)
          0: begin m_left--; if (m_left == 0) begin m_phase = 1; m_left = STAB; end end
          1: begin m_left--; if (m_left == 0) m_phase = 2; end
          2: m_phase = 3;
          default: m_phase = 4;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 model pad", pin, m_phase == 0);
      chk("R7 model core", core, m_phase != 4);
      chk("R6 model fetch", fetch, m_phase == 2 || m_phase == 3);
      chk("R6 model addr", addr, m_phase == 2 ? 16'hFFFE : (m_phase == 3 ? 16'hFFFF : 16'h0));
      chk("R9 model flags", flags, {m_wf, m_lf});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // called at a negedge in the first delay cycle
  task automatic run_seq(int dly, string tag);
    int n = 0, n2 = 0, nf = 0;
    while (pin) begin n++; @(negedge clk); end
    chk({tag, " R2 delay length"}, n, dly);
    while (core) begin
      if (fetch) begin
        chk("R6 fetch addr", addr, nf == 0 ? 16'hFFFE : 16'hFFFF);
        nf++;
      end
      if (pin) chk("R5 pad released", pin, 0);
      n2++;
      @(negedge clk);
    end
    chk("R5 stab+fetch length", n2, STAB + 2);
    chk("R6 fetch cycles", nf, 2);
    repeat (3) @(negedge clk);
    chk("R7 core released", core, 0);
  endtask

  task automatic ext_pulse(int len);
    ext_n = 0;
    repeat (len) @(negedge clk);
    ext_n = 1;
  endtask

  task automatic wait_pad(string tag);
    int t = 0;
    while (!pin && t < 20) begin t++; @(negedge clk); end
    chk(tag, pin, 1);
  endtask

  initial begin
    rst = 1; ext_n = 1; lvd = 0; wdg = 0; fwr = 0; fwd = 2'b00;
    repeat (3) @(negedge clk);
    chk("R12 pad in reset", pin, 1);
    chk("R12 core in reset", core, 1);
    chk("R12 flags cleared", flags, 0);
    rst = 0;
    run_seq(EXTH, "R12 power-on");

    // R4: too short a pulse
    ext_pulse(FILT - 1);
    repeat (10) @(negedge clk);
    chk("R4 short pulse pad", pin, 0);
    chk("R4 short pulse core", core, 0);

    // R1 external source
    ext_pulse(FILT);
    wait_pad("R1 ext recognised");
    run_seq(EXTH, "R1 ext");
    chk("R9 ext sets no flag", flags, 2'b00);

    // R1 watchdog source
    wdg = 1; @(negedge clk); wdg = 0;
    chk("R1 wdg starts", pin, 1);
    run_seq(WDGH, "R1 wdg");
    chk("R9 wdg flag", flags, 2'b10);

    // R3 low voltage held
    lvd = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk("R3 pad held by lvd", pin, 1);
    end
    lvd = 0;
    run_seq(LVDH, "R3 lvd tail");
    chk("R9 lvd flag", flags, 2'b11);

    // R10 clear lvd only, then both
    fwr = 1; fwd = 2'b10; @(negedge clk); fwr = 0;
    chk("R10 selective clear", flags, 2'b10);
    fwr = 1; fwd = 2'b00; @(negedge clk); fwr = 0;
    chk("R10 clear all", flags, 2'b00);

    // R11 set and clear in same cycle
    wdg = 1; fwr = 1; fwd = 2'b00; @(negedge clk); wdg = 0; fwr = 0;
    chk("R11 set wins", flags, 2'b10);
    run_seq(WDGH, "R11");

    // R8 restart during fetch
    wdg = 1; @(negedge clk); wdg = 0;
    while (!fetch) @(negedge clk);
    wdg = 1; @(negedge clk); wdg = 0;
    chk("R8 restart in fetch pad", pin, 1);
    chk("R8 restart in fetch no fetch", fetch, 0);
    run_seq(WDGH, "R8 fetch");

    // R8 restart during stabilisation
    wdg = 1; @(negedge clk); wdg = 0;
    while (pin) @(negedge clk);
    repeat (100) @(negedge clk);
    ext_pulse(FILT);
    wait_pad("R8 restart in stab");
    run_seq(EXTH, "R8 stab");

    // R1 priority: lvd and wdg together
    lvd = 1; wdg = 1; @(negedge clk); lvd = 0; wdg = 0;
    run_seq(LVDH, "R1 priority");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule